// File: doc/BRIEF.md
# Audio Subframe Packer

This block sits between an audio sample stream and a display-link transmitter. It takes interleaved 32-bit words, one per channel, in order, with 2 to 8 channels in a frame. Each word leaves as a 32-bit subframe word in the layout the link expects. Input and output both use valid/ready handshakes, and a single output register between them carries the state.

The block has two modes. In raw mode each word holds a 24-bit sample. The packer adds the consumer channel-status bit for the current frame, the channel number carried inside that status, a block-start marker and even parity. The status comes from a 192-frame position tracker that all channels of a frame share. In pass-through mode each word is already a complete subframe. The packer only moves the audio and flag fields down by four bits and turns the low preamble code into the block-start marker. A byte-wide configuration port loads the 32 channel-status bits that software defines. A restart strobe returns the position tracker to the start of a block.

Top module: `iec_subframe_packer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: in_ready equals (not out_valid) or out_ready. An accepted word appears on the output in the next cycle. While out_valid is high and out_ready is low, out_valid and out_data hold.
- R3: In raw mode (raw_mode=1), output bits 23..0 equal input bits 23..0. Output bits 31..29, 25 and 24 are 0.
- R4: In raw mode, output bit 26 carries status bit f, where f is the frame index. For f below 32 that is bit f%8 of configuration byte f/8, with the byte selected by cfg_addr. For f from 32 to 191 it is 0.
- R5: In raw mode, for frames 20 to 23 the status bit is instead bit (f-20) of the value c+1, where c is the channel index 0..7.
- R6: In raw mode, output bit 28 is 1 exactly when the word is at frame 0 and channel 0.
- R7: In raw mode, output bit 27 makes the XOR of output bits 27..0 equal 0 (even parity).
- R8: Every accepted word moves the channel index up by one. When the index reaches the channel count it wraps to 0 and the frame index advances. Frame 191 is followed by frame 0.
- R9: A chan_count below 2 acts as 2, and a chan_count above 8 acts as 8.
- R10: A word accepted while restart is high is packed as frame 0, channel 0. A restart with no accepted word makes the next accepted word frame 0, channel 0.
- R11: In pass-through mode (raw_mode=0), out_data equals in_data shifted right by 4, with output bit 28 set to input bit 3 and output bits 31..29 set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Return the frame and channel position to zero |
| raw_mode | input | 1 | 1: 24-bit sample mode, 0: pass-through |
| chan_count | input | 4 | Channels per frame (clamped to 2..8) |
| cfg_we | input | 1 | Write strobe for a channel-status byte |
| cfg_addr | input | 2 | Channel-status byte select |
| cfg_data | input | 8 | Channel-status byte value |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input sample or subframe |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 32 | Packed subframe word |

## Verification
Two things can happen in the same cycle. A restart strobe can arrive together with a word being accepted, and an output word can drain in the cycle a new word loads. The bench drives restart on words in the middle of a frame and at random points in the block. It also throttles out_ready at random, so that loads and drains overlap. Each output word is compared with a model that moves the position to zero before it stamps the restarted word. That model also confirms that no word is lost or repeated when a drain and a load share a cycle.

// File: rtl/spk_pkg.sv
package spk_pkg;
    localparam int WORD_W     = 32;
    localparam int CS_BYTES   = 4;
    localparam int CS_BITS    = CS_BYTES * 8;
    localparam int CS_IDX_W   = $clog2(CS_BITS);
    localparam int CS_ADDR_W  = $clog2(CS_BYTES);
    localparam int FRAMES     = 192;
    localparam int FRAME_W    = $clog2(FRAMES);
    localparam int MIN_CH     = 2;
    localparam int MAX_CH     = 8;
    localparam int CH_W       = $clog2(MAX_CH);
    localparam int CNT_W      = 4;
    localparam int CH_NUM_LSB = 20;
    localparam int CH_NUM_W   = 4;
    localparam int AUD_W      = 24;
    localparam int CS_POS     = 26;
    localparam int PAR_POS    = 27;
    localparam int BLK_POS    = 28;
    localparam int PT_SHIFT   = 4;
    localparam int PT_BLK_IN  = 3;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [CH_W-1:0]    chan;
    } pos_t;
endpackage

// File: rtl/spk_position.sv
module spk_position
    import spk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    input  logic [CNT_W-1:0] chan_count,
    output pos_t             cur_pos
);
    typedef struct packed {
        pos_t pos;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] lim;
    pos_t base;

    always_comb begin
        if (chan_count < CNT_W'(MIN_CH))      lim = CNT_W'(MIN_CH);
        else if (chan_count > CNT_W'(MAX_CH)) lim = CNT_W'(MAX_CH);
        else                                  lim = chan_count;

        base = restart ? '0 : st_q.pos;
        st_d = st_q;
        if (restart) st_d.pos = '0;
        if (advance) begin
            if ((CNT_W'(base.chan) + CNT_W'(1)) >= lim) begin
                st_d.pos.chan  = '0;
                st_d.pos.frame = (base.frame == FRAME_W'(FRAMES - 1)) ? '0
                                 : base.frame + FRAME_W'(1);
            end else begin
                st_d.pos.chan  = base.chan + CH_W'(1);
                st_d.pos.frame = base.frame;
            end
        end
        cur_pos = base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spk_chan_status.sv
module spk_chan_status
    import spk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CS_ADDR_W-1:0] cfg_addr,
    input  logic [7:0]           cfg_data,
    input  pos_t                 pos,
    output logic                 cs_bit
);
    typedef struct packed {
        logic [CS_BYTES-1:0][7:0] bytes;
    } st_t;

    st_t st_d, st_q;
    logic [CS_BITS-1:0]  flat;
    logic [CH_NUM_W-1:0] ch_num;

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.bytes[cfg_addr] = cfg_data;

        ch_num = CH_NUM_W'(pos.chan) + CH_NUM_W'(1);
        flat   = st_q.bytes;
        flat[CH_NUM_LSB +: CH_NUM_W] = ch_num;
        if (pos.frame < FRAME_W'(CS_BITS)) cs_bit = flat[pos.frame[CS_IDX_W-1:0]];
        else                               cs_bit = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spk_format.sv
module spk_format
    import spk_pkg::*;
(
    input  logic              raw_mode,
    input  logic [WORD_W-1:0] in_word,
    input  logic              cs_bit,
    input  logic              blk_start,
    output logic [WORD_W-1:0] out_word
);
    always_comb begin
        out_word = '0;
        if (raw_mode) begin
            out_word[AUD_W-1:0] = in_word[AUD_W-1:0];
            out_word[CS_POS]    = cs_bit;
            out_word[BLK_POS]   = blk_start;
            out_word[PAR_POS]   = ^out_word[CS_POS:0];
        end else begin
            out_word          = in_word >> PT_SHIFT;
            out_word[BLK_POS] = in_word[PT_BLK_IN];
        end
    end
endmodule

// File: rtl/iec_subframe_packer.sv
module iec_subframe_packer
    import spk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 raw_mode,
    input  logic [CNT_W-1:0]     chan_count,
    input  logic                 cfg_we,
    input  logic [CS_ADDR_W-1:0] cfg_addr,
    input  logic [7:0]           cfg_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WORD_W-1:0]    in_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [WORD_W-1:0]    out_data
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } st_t;

    st_t st_d, st_q;
    pos_t cur_pos;
    logic accept, cs_bit, blk_start;
    logic [WORD_W-1:0] packed_word;

    spk_position u_pos (
        .clk(clk), .rst_n(rst_n), .restart(restart), .advance(accept),
        .chan_count(chan_count), .cur_pos(cur_pos)
    );

    spk_chan_status u_cs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .pos(cur_pos), .cs_bit(cs_bit)
    );

    spk_format u_fmt (
        .raw_mode(raw_mode), .in_word(in_data), .cs_bit(cs_bit),
        .blk_start(blk_start), .out_word(packed_word)
    );

    always_comb begin
        in_ready  = !st_q.vld || out_ready;
        accept    = in_valid && in_ready;
        blk_start = (cur_pos.frame == '0) && (cur_pos.chan == '0);
        st_d = st_q;
        if (accept) begin
            st_d.vld  = 1'b1;
            st_d.data = packed_word;
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
        out_valid = st_q.vld;
        out_data  = st_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spk_checker.sv
module spk_checker
    import spk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              raw_mode,
    input logic              in_valid,
    input logic              in_ready,
    input logic [WORD_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic [FRAME_W-1:0] cur_frame,
    input logic [CH_W-1:0]   cur_chan
);
    logic acc;
    assign acc = in_valid && in_ready;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R2
    AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid); // R2
    AST_RAW_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        acc && raw_mode |=> out_data[AUD_W-1:0] == $past(in_data[AUD_W-1:0])
            && out_data[31:29] == 3'b000 && out_data[25:24] == 2'b00); // R3
    AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        acc && raw_mode |=> (^out_data[PAR_POS:0]) == 1'b0); // R7
    AST_BLK_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        acc && raw_mode && (cur_chan != '0 || cur_frame != '0) |=> !out_data[BLK_POS]); // R6
    AST_PASS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !raw_mode |=> out_data == {3'b000, $past(in_data[PT_BLK_IN]), $past(in_data[31:4])}); // R11
    AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_frame < FRAME_W'(FRAMES)); // R8
endmodule

bind iec_subframe_packer spk_checker u_chk (
    .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data),
    .cur_frame(cur_pos.frame), .cur_chan(cur_pos.chan)
);

// File: tb/sim_iec_subframe_packer.sv
module sim_iec_subframe_packer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 0, rst_n = 0, restart = 0, raw_mode = 1;
    logic [3:0] chan_count = 4'd2;
    logic cfg_we = 0;
    logic [1:0] cfg_addr = 0;
    logic [7:0] cfg_data = 0;
    logic in_valid = 0, in_ready, out_valid, out_ready = 1;
    logic [31:0] in_data = 0, out_data;

    int checks = 0, errors = 0, cyc = 0;
    int m_fr = 0, m_ch = 0;
    logic [7:0] cfg_m [4];
    logic [31:0] exp_q [$];
    string ctx_q [$];
    string ctx = "R3";
    bit throttle = 0, stall_prev = 0, done = 0;
    logic [31:0] stall_data;

    iec_subframe_packer u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart), .raw_mode(raw_mode),
        .chan_count(chan_count), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int lim_of(logic [3:0] c);
        if (c < 2) return 2;      // R9
        if (c > 8) return 8;      // R9
        return int'(c);
    endfunction

    function automatic logic [31:0] exp_word(logic [31:0] d, bit raw, int fr, int ch);
        logic [31:0] w;
        logic cs;
        if (!raw) return {3'b000, d[3], d[31:4]};                 // R11
        if (fr >= 20 && fr <= 23) cs = 1'((ch + 1) >> (fr - 20));  // R5
        else if (fr < 32) cs = cfg_m[fr / 8][fr % 8];              // R4
        else cs = 1'b0;
        w = '0;
        w[23:0] = d[23:0];                                         // R3
        w[26] = cs;
        w[28] = (fr == 0 && ch == 0);                              // R6
        w[27] = ^{cs, d[23:0]};                                    // R7
        return w;
    endfunction

    function automatic string tag_of(logic [31:0] diff, string c);
        if (diff[28]) return {c, "/R6"};
        if (diff[27]) return {c, "/R7"};
        if (diff[26]) return {c, "/R4"};
        return c;
    endfunction

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            errors++;
            $display("FAIL watchdog R2 got hang expected completion");
            report();
        end
    end

    always @(negedge clk) out_ready = throttle ? (($urandom % 4) != 0) : 1'b1;

    always @(negedge clk) begin
        #4;
        if (rst_n) begin
            if (stall_prev) begin
                checks++;
                if (!out_valid || out_data !== stall_data) begin
                    errors++;
                    $display("FAIL R2 stall got %0b/%h expected 1/%h", out_valid, out_data, stall_data);
                end
            end
            if (out_valid && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 got extra word %h expected none", out_data);
                end else begin
                    logic [31:0] e;
                    string c;
                    e = exp_q.pop_front();
                    c = ctx_q.pop_front();
                    if (out_data !== e) begin
                        errors++;
                        $display("FAIL %s got %h expected %h", tag_of(out_data ^ e, c), out_data, e);
                    end
                end
            end
            stall_prev = out_valid && !out_ready;
            stall_data = out_data;
        end
    end

    task automatic send(logic [31:0] d, bit rs);
        in_valid = 1; in_data = d; restart = rs;
        forever begin
            #4;
            if (in_ready) begin
                if (rs) begin m_fr = 0; m_ch = 0; end   // R10
                exp_q.push_back(exp_word(d, raw_mode, m_fr, m_ch));
                ctx_q.push_back(ctx);
                m_ch++;                                  // R8
                if (m_ch >= lim_of(chan_count)) begin
                    m_ch = 0;
                    m_fr = (m_fr + 1) % 192;
                end
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid = 0; restart = 0;
    endtask

    task automatic restart_idle();
        restart = 1;
        @(negedge clk);
        restart = 0;
        m_fr = 0; m_ch = 0;                              // R10
    endtask

    task automatic cfg_write(int a, logic [7:0] v);
        cfg_we = 1; cfg_addr = 2'(a); cfg_data = v;
        @(negedge clk);
        cfg_we = 0;
        cfg_m[a] = v;
    endtask

    task automatic burst(int n, bit rs_first);
        for (int i = 0; i < n; i++) send($urandom, rs_first && i == 0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h1f2e3d4c));
        for (int i = 0; i < 4; i++) cfg_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #4;
        checks++;  // R1
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 got valid=%0b ready=%0b expected 0/1", out_valid, in_ready);
        end
        @(negedge clk);
        for (int i = 0; i < 4; i++) cfg_write(i, 8'($urandom));  // R4

        ctx = "R8"; chan_count = 4'd2;
        burst(192 * 2 + 6, 1);
        throttle = 1;
        ctx = "R2"; chan_count = 4'd8; burst(200, 1);
        ctx = "R5"; chan_count = 4'd5; burst(130, 1);
        ctx = "R9"; chan_count = 4'd1; burst(70, 1);
        ctx = "R9"; chan_count = 4'd13; burst(200, 1);
        ctx = "R10"; chan_count = 4'd6;
        for (int k = 0; k < 6; k++) begin
            burst(int'($urandom % 40) + 3, 0);
            send($urandom, 1);
        end
        burst(10, 0);
        restart_idle();
        burst(12, 0);
        drain();
        cfg_write(0, 8'hA5); cfg_write(3, 8'h3C);  // R4
        ctx = "R4"; chan_count = 4'd2; burst(70, 1);
        ctx = "R3"; send(32'h0000_0000, 1); send(32'hFFFF_FFFF, 0); send(32'hAB00_0000, 0);
        raw_mode = 0; ctx = "R11";
        send(32'h0000_0008, 0); send(32'hF000_0007, 0); send(32'hFFFF_FFFF, 1);
        burst(100, 0);
        drain();
        throttle = 0;
        done = 1;
        report();
    end
endmodule